// File: doc/BRIEF.md
# Write-Through FIFO Set-Associative Cache

This block is a parameterized set-associative cache that sits between a requester and a next-level memory. The requester issues loads, stores and read-modify-write accesses on byte addresses. Each access touches bytes of a single block, selected by a per-byte lane mask. The cache geometry comes from three parameters: the number of set-index bits, the number of ways per set and the number of block-offset bits. With zero set-index bits the cache is fully associative.

Stores are written through to the next level on every access. A store that misses does not allocate a line. A load miss fetches the whole block over a held read request and fills a line. Each set chooses its victim in first-in, first-out order through a fill pointer, and hits never change that order. Three counters record hits, misses and evictions, and all three are visible on output ports at all times.

Top module: `wtc_cache`

## Requirements
- R1: The address is split into three fields. The block offset is the low B_BITS bits, the set index is the next S_BITS bits and the tag is the rest. Blocks in different sets never displace each other. Byte lane i of every data bus holds the byte at block offset i.
- R2: A load hit returns one response with rsp_hit=1. The response carries the line's bytes on the lanes selected by req_be and zero on every other lane. The hit counter rises by one and no next-level read or write occurs.
- R3: On a load miss, the miss counter rises by one. The block raises mem_rd_req with a block-aligned mem_rd_addr and holds both until mem_rd_done. It then fills the line and responds with rsp_hit=0 and the masked bytes of mem_rd_data.
- R4: A store hit updates the selected bytes of the cached line and raises the hit counter by one. It also issues exactly one mem_wr_valid pulse carrying the block-aligned address, req_be and the write data.
- R5: A store miss raises the miss counter by one and issues one next-level write. It issues no next-level read and allocates no line, so a later load to that block misses.
- R6: Each set fills its ways in round-robin order through a pointer that wraps at WAYS. When the set is full, the victim is the earliest-filled line, even if that line was hit since.
- R7: The eviction counter rises only when a fill replaces a valid line. Filling an invalid way does not count as an eviction.
- R8: A modify (req_op=2) runs a load phase and then a store phase at the same address, and the store phase always hits. The response carries the pre-store bytes, and rsp_hit reports the load phase. One next-level write is issued. Two accesses are counted.
- R9: A synchronous active-high reset clears every valid bit, every fill pointer and all three counters.
- R10: req_ready is high only when the block is idle, and a request is taken on a clock edge where req_valid and req_ready are both high. req_op uses 0 for load, 1 for store, 2 for modify, and 3 behaves as a load. Each request produces exactly one single-cycle rsp_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 0 load, 1 store, 2 modify, 3 load |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 2**B_BITS | Byte lanes touched |
| req_wdata | input | 8*2**B_BITS | Store data, lane-aligned |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Access (load phase for modify) hit |
| rsp_rdata | output | 8*2**B_BITS | Loaded bytes, unselected lanes zero |
| mem_rd_req | output | 1 | Block read request, held until done |
| mem_rd_addr | output | ADDR_W | Block-aligned read address |
| mem_rd_done | input | 1 | Read data valid, one cycle |
| mem_rd_data | input | 8*2**B_BITS | Returned block |
| mem_wr_valid | output | 1 | Write-through pulse |
| mem_wr_addr | output | ADDR_W | Block-aligned write address |
| mem_wr_be | output | 2**B_BITS | Write byte lanes |
| mem_wr_data | output | 8*2**B_BITS | Write data |
| hit_cnt | output | CNT_W | Hit counter |
| miss_cnt | output | CNT_W | Miss counter |
| evict_cnt | output | CNT_W | Eviction counter |

## Verification
The assertions assume that the next level raises mem_rd_done only while mem_rd_req is high. They also assume the next level accepts every write pulse at once. The stimulus meets both conditions, since the bench memory answers each held read after a fixed delay and absorbs writes in the same cycle. The assertions further assume that the counters never wrap. The bench keeps well under that limit with a few hundred accesses. It confines random addresses to a small window, so sets refill often and evictions take place, and every byte mask is drawn non-zero.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_MODIFY = 2'd2,
    OP_RSVD   = 2'd3
  } wtc_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_RDATA,
    ST_FILL,
    ST_MSTORE
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int WAYS  = 4,
  parameter int SET_W = 1,
  parameter int WAY_W = 2,
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [WAY_W-1:0] lk_way,
  output logic [WAY_W-1:0] vic_way,
  output logic             vic_valid,
  input  logic             fill_en
);
  localparam int NSET = 1 << SET_W;
  localparam int NWAY = 1 << WAY_W;

  logic [TAG_W-1:0] tag_q   [NSET][NWAY];
  logic             valid_q [NSET][NWAY];
  logic [WAY_W-1:0] ptr_q   [NSET];
  logic [WAYS-1:0]  hv;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hv[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  always_comb begin
    lk_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hv[w]) lk_way = WAY_W'(w);
    end
  end

  assign lk_hit    = |hv;
  assign vic_way   = ptr_q[lk_set];
  assign vic_valid = valid_q[lk_set][vic_way];

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[lk_set][vic_way] <= lk_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSET; s++) begin
        ptr_q[s] <= '0;
        for (int w = 0; w < NWAY; w++) valid_q[s][w] <= 1'b0;
      end
    end else if (fill_en) begin
      valid_q[lk_set][vic_way] <= 1'b1;
      ptr_q[lk_set] <= (vic_way == WAY_W'(WAYS - 1)) ? '0 : vic_way + 1'b1;
    end
  end
endmodule

// File: rtl/wtc_data_ram.sv
module wtc_data_ram #(
  parameter int AW     = 3,
  parameter int NBYTES = 4
) (
  input  logic                clk,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [NBYTES-1:0]   wbe,
  input  logic [NBYTES*8-1:0] wdata,
  input  logic [AW-1:0]       raddr,
  output logic [NBYTES*8-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] rd_q;
    always_ff @(posedge clk) begin
      if (we && wbe[i]) mem[waddr] <= wdata[i*8 +: 8];
      rd_q <= mem[raddr];
    end
    assign rdata[i*8 +: 8] = rd_q;
  end
endmodule

// File: rtl/wtc_stat_counters.sv
module wtc_stat_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_hit,
  input  logic             inc_miss,
  input  logic             inc_evict,
  output logic [CNT_W-1:0] hit_cnt,
  output logic [CNT_W-1:0] miss_cnt,
  output logic [CNT_W-1:0] evict_cnt
);
  localparam int NCNT = 3;
  logic [NCNT-1:0]  inc;
  logic [CNT_W-1:0] cnt_q [NCNT];

  assign inc = {inc_evict, inc_miss, inc_hit};

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)         cnt_q[k] <= '0;
      else if (inc[k]) cnt_q[k] <= cnt_q[k] + 1'b1;
    end
  end

  assign hit_cnt   = cnt_q[0];
  assign miss_cnt  = cnt_q[1];
  assign evict_cnt = cnt_q[2];
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int S_BITS = 1,
  parameter int WAYS   = 4,
  parameter int B_BITS = 2,   // must be at least 1
  parameter int CNT_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [1:0]                 req_op,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [(1<<B_BITS)-1:0]     req_be,
  input  logic [8*(1<<B_BITS)-1:0]   req_wdata,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic [8*(1<<B_BITS)-1:0]   rsp_rdata,
  output logic                       mem_rd_req,
  output logic [ADDR_W-1:0]          mem_rd_addr,
  input  logic                       mem_rd_done,
  input  logic [8*(1<<B_BITS)-1:0]   mem_rd_data,
  output logic                       mem_wr_valid,
  output logic [ADDR_W-1:0]          mem_wr_addr,
  output logic [(1<<B_BITS)-1:0]     mem_wr_be,
  output logic [8*(1<<B_BITS)-1:0]   mem_wr_data,
  output logic [CNT_W-1:0]           hit_cnt,
  output logic [CNT_W-1:0]           miss_cnt,
  output logic [CNT_W-1:0]           evict_cnt
);
  localparam int BLK_BYTES = 1 << B_BITS;
  localparam int BLK_W     = 8 * BLK_BYTES;
  localparam int SET_W     = (S_BITS > 0) ? S_BITS : 1;
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W     = ADDR_W - S_BITS - B_BITS;
  localparam int RAM_AW    = SET_W + WAY_W;

  wtc_state_e              state_q;
  wtc_op_e                 op_q;
  logic [ADDR_W-1:0]       addr_q;
  logic [BLK_BYTES-1:0]    be_q;
  logic [BLK_W-1:0]        wdata_q;
  logic [WAY_W-1:0]        way_q;
  logic                    hit_q;

  logic [SET_W-1:0]        set_idx;
  logic [TAG_W-1:0]        tag_idx;
  logic [ADDR_W-1:0]       blk_addr;
  logic                    lk_hit, vic_valid, fill_en;
  logic [WAY_W-1:0]        lk_way, vic_way;
  logic                    ram_we;
  logic [RAM_AW-1:0]       ram_waddr;
  logic [BLK_BYTES-1:0]    ram_wbe;
  logic [BLK_W-1:0]        ram_wdata, ram_rdata;
  logic                    is_store;

  if (S_BITS == 0) begin : g_fully
    assign set_idx = '0;
  end else begin : g_sets
    assign set_idx = addr_q[B_BITS +: S_BITS];
  end
  assign tag_idx  = addr_q[ADDR_W-1 -: TAG_W];
  assign blk_addr = {addr_q[ADDR_W-1:B_BITS], {B_BITS{1'b0}}};
  assign is_store = (op_q == OP_STORE);

  function automatic logic [BLK_W-1:0] lane_mask(input logic [BLK_W-1:0] d,
                                                 input logic [BLK_BYTES-1:0] be);
    logic [BLK_W-1:0] r;
    for (int i = 0; i < BLK_BYTES; i++) r[i*8 +: 8] = be[i] ? d[i*8 +: 8] : 8'h00;
    return r;
  endfunction

  assign fill_en = (state_q == ST_FILL) && mem_rd_done;

  wtc_tag_store #(
    .WAYS (WAYS), .SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W)
  ) u_tags (
    .clk(clk), .rst(rst), .lk_set(set_idx), .lk_tag(tag_idx),
    .lk_hit(lk_hit), .lk_way(lk_way), .vic_way(vic_way),
    .vic_valid(vic_valid), .fill_en(fill_en)
  );

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = {set_idx, lk_way};
    ram_wbe   = be_q;
    ram_wdata = wdata_q;
    case (state_q)
      ST_LOOKUP: ram_we = is_store && lk_hit;
      ST_FILL: begin
        ram_we    = mem_rd_done;
        ram_waddr = {set_idx, vic_way};
        ram_wbe   = '1;
        ram_wdata = mem_rd_data;
      end
      ST_MSTORE: begin
        ram_we    = 1'b1;
        ram_waddr = {set_idx, way_q};
      end
      default: ram_we = 1'b0;
    endcase
  end

  wtc_data_ram #(.AW(RAM_AW), .NBYTES(BLK_BYTES)) u_data (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wbe(ram_wbe),
    .wdata(ram_wdata), .raddr({set_idx, lk_way}), .rdata(ram_rdata)
  );

  wtc_stat_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .inc_hit((state_q == ST_LOOKUP && lk_hit) || state_q == ST_MSTORE),
    .inc_miss(state_q == ST_LOOKUP && !lk_hit),
    .inc_evict(fill_en && vic_valid),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .evict_cnt(evict_cnt)
  );

  assign req_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      op_q         <= OP_LOAD;
      addr_q       <= '0;
      be_q         <= '0;
      wdata_q      <= '0;
      way_q        <= '0;
      hit_q        <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_rdata    <= '0;
      mem_rd_req   <= 1'b0;
      mem_rd_addr  <= '0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_be    <= '0;
      mem_wr_data  <= '0;
    end else begin
      rsp_valid    <= 1'b0;
      mem_wr_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            op_q    <= (req_op == OP_RSVD) ? OP_LOAD : wtc_op_e'(req_op);
            addr_q  <= req_addr;
            be_q    <= req_be;
            wdata_q <= req_wdata;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          hit_q <= lk_hit;
          if (is_store) begin
            mem_wr_valid <= 1'b1;
            mem_wr_addr  <= blk_addr;
            mem_wr_be    <= be_q;
            mem_wr_data  <= wdata_q;
            rsp_valid    <= 1'b1;
            rsp_hit      <= lk_hit;
            rsp_rdata    <= '0;
            state_q      <= ST_IDLE;
          end else if (lk_hit) begin
            way_q   <= lk_way;
            state_q <= ST_RDATA;
          end else begin
            way_q       <= vic_way;
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= blk_addr;
            state_q     <= ST_FILL;
          end
        end
        ST_RDATA: begin
          rsp_rdata <= lane_mask(ram_rdata, be_q);
          if (op_q == OP_MODIFY) begin
            state_q <= ST_MSTORE;
          end else begin
            rsp_valid <= 1'b1;
            rsp_hit   <= hit_q;
            state_q   <= ST_IDLE;
          end
        end
        ST_FILL: begin
          if (mem_rd_done) begin
            mem_rd_req <= 1'b0;
            rsp_rdata  <= lane_mask(mem_rd_data, be_q);
            if (op_q == OP_MODIFY) begin
              state_q <= ST_MSTORE;
            end else begin
              rsp_valid <= 1'b1;
              rsp_hit   <= 1'b0;
              state_q   <= ST_IDLE;
            end
          end
        end
        ST_MSTORE: begin
          mem_wr_valid <= 1'b1;
          mem_wr_addr  <= blk_addr;
          mem_wr_be    <= be_q;
          mem_wr_data  <= wdata_q;
          rsp_valid    <= 1'b1;
          rsp_hit      <= hit_q;
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wtc_cache_chk.sv
module wtc_cache_chk #(
  parameter int ADDR_W = 12,
  parameter int B_BITS = 2,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_done,
  input logic              mem_wr_valid,
  input logic [CNT_W-1:0]  miss_cnt,
  input logic [CNT_W-1:0]  evict_cnt
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_done) |=> (mem_rd_req && $stable(mem_rd_addr))); // R3
  AST_RD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> (mem_rd_addr[B_BITS-1:0] == '0)); // R1
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> !req_ready); // R10
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R10
  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_req && mem_wr_valid)); // R5
  AST_EVICT_ON_FILL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && evict_cnt != $past(evict_cnt)) |-> $past(mem_rd_done && mem_rd_req)); // R7
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (miss_cnt == $past(miss_cnt) || miss_cnt == $past(miss_cnt) + 1'b1)); // R3
endmodule

bind wtc_cache wtc_cache_chk #(.ADDR_W(ADDR_W), .B_BITS(B_BITS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_done(mem_rd_done),
  .mem_wr_valid(mem_wr_valid), .miss_cnt(miss_cnt), .evict_cnt(evict_cnt)
);

// File: tb/wtc_cache_bench.sv
module wtc_cache_bench;
  localparam int ADDR_W = 12, S_BITS = 1, WAYS = 4, B_BITS = 2, CNT_W = 16;
  localparam int NB = 1 << B_BITS, BW = 8 * NB, NSETS = 1 << S_BITS;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [NB-1:0] req_be = '0;
  logic [BW-1:0] req_wdata = '0;
  logic rsp_valid, rsp_hit;
  logic [BW-1:0] rsp_rdata;
  logic mem_rd_req, mem_rd_done = 1'b0;
  logic [ADDR_W-1:0] mem_rd_addr, mem_wr_addr;
  logic [BW-1:0] mem_rd_data = '0, mem_wr_data;
  logic mem_wr_valid;
  logic [NB-1:0] mem_wr_be;
  logic [CNT_W-1:0] hit_cnt, miss_cnt, evict_cnt;

  always #2 clk = ~clk;

  wtc_cache #(.ADDR_W(ADDR_W), .S_BITS(S_BITS), .WAYS(WAYS), .B_BITS(B_BITS), .CNT_W(CNT_W))
  u_wtc_cache (.*);

  int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0;
  logic [ADDR_W-1:0] wr_addr_s;
  logic [NB-1:0] wr_be_s;
  logic [BW-1:0] wr_data_s;
  logic [7:0] ref_mem [1 << ADDR_W];
  int ref_tag [NSETS][WAYS];
  bit ref_val [NSETS][WAYS];
  int ref_ptr [NSETS];
  int e_hit = 0, e_miss = 0, e_ev = 0;
  bit done_run = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [BW-1:0] blk_of(input int a);
    logic [BW-1:0] r;
    for (int i = 0; i < NB; i++) r[i*8 +: 8] = ref_mem[(a & ~(NB - 1)) + i];
    return r;
  endfunction

  function automatic logic [BW-1:0] msk(input logic [BW-1:0] d, input logic [NB-1:0] be);
    logic [BW-1:0] r;
    for (int i = 0; i < NB; i++) r[i*8 +: 8] = be[i] ? d[i*8 +: 8] : 8'h00;
    return r;
  endfunction

  task automatic ref_reset();
    for (int s = 0; s < NSETS; s++) begin
      ref_ptr[s] = 0;
      for (int w = 0; w < WAYS; w++) ref_val[s][w] = 0;
    end
    e_hit = 0; e_miss = 0; e_ev = 0;
  endtask

  // memory model: answers a held read after three cycles
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (mem_rd_done) mem_rd_done = 1'b0;
      else if (mem_rd_req) begin
        lat++;
        if (lat == 3) begin
          mem_rd_data = blk_of(int'(mem_rd_addr));
          mem_rd_done = 1'b1;
          n_rd++;
          lat = 0;
        end
      end else lat = 0;
    end
  end

  always @(posedge clk) begin
    if (mem_wr_valid) begin
      n_wr++;
      wr_addr_s = mem_wr_addr;
      wr_be_s   = mem_wr_be;
      wr_data_s = mem_wr_data;
    end
  end

  // one access; returns the observed hit flag
  task automatic access(input int op, input int addr, input logic [NB-1:0] be,
                        input logic [BW-1:0] wd, output bit got_hit);
    int set = (addr >> B_BITS) & (NSETS - 1);
    int tag = addr >> (B_BITS + S_BITS);
    int hw = -1, rd0 = n_rd, wr0 = n_wr, t = 0;
    bit is_st = (op == 1), is_md = (op == 2);
    bit exp_hit;
    logic [BW-1:0] exp_rd;
    string rq;
    for (int w = 0; w < WAYS; w++) if (ref_val[set][w] && ref_tag[set][w] == tag) hw = w;
    exp_hit = (hw >= 0);
    exp_rd  = msk(blk_of(addr), be);
    rq = is_md ? "R8" : is_st ? (exp_hit ? "R4" : "R5") : (exp_hit ? "R2" : "R3");
    // reference update
    if (exp_hit) e_hit++; else e_miss++;
    if (!is_st && !exp_hit) begin
      if (ref_val[set][ref_ptr[set]]) e_ev++;
      ref_tag[set][ref_ptr[set]] = tag;
      ref_val[set][ref_ptr[set]] = 1;
      ref_ptr[set] = (ref_ptr[set] + 1) % WAYS;
    end
    if (is_md) e_hit++;
    // drive
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = ADDR_W'(addr); req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
    check({rq, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    got_hit = rsp_hit;
    check({rq, " rsp_hit"}, 64'(rsp_hit), 64'(exp_hit));
    if (!is_st) check({rq, " rdata"}, 64'(rsp_rdata), 64'(exp_rd));
    check({rq, " hit_cnt"}, 64'(hit_cnt), 64'(e_hit));
    check({rq, " miss_cnt"}, 64'(miss_cnt), 64'(e_miss));
    check({rq, " R7 evict_cnt"}, 64'(evict_cnt), 64'(e_ev));
    @(negedge clk);
    check({rq, " rsp_valid pulse R10"}, 64'(rsp_valid), 64'd0);
    check({rq, " reads"}, 64'(n_rd - rd0), 64'((!is_st && !exp_hit) ? 1 : 0));
    check({rq, " writes"}, 64'(n_wr - wr0), 64'((is_st || is_md) ? 1 : 0));
    if (is_st || is_md) begin
      check({rq, " wr addr R1"}, 64'(wr_addr_s), 64'(addr & ~(NB - 1)));
      check({rq, " wr be"}, 64'(wr_be_s), 64'(be));
      check({rq, " wr data"}, 64'(msk(wr_data_s, be)), 64'(msk(wd, be)));
      for (int i = 0; i < NB; i++)
        if (be[i]) ref_mem[(addr & ~(NB - 1)) + i] = wd[i*8 +: 8];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit h;
    void'($urandom(32'd4242));
    for (int i = 0; i < (1 << ADDR_W); i++) ref_mem[i] = 8'(i * 13 + 5);
    ref_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 hit_cnt", 64'(hit_cnt), 0);
    check("R9 miss_cnt", 64'(miss_cnt), 0);
    check("R9 evict_cnt", 64'(evict_cnt), 0);
    check("R10 ready idle", 64'(req_ready), 1);
    check("R10 rsp idle", 64'(rsp_valid), 0);
    check("R3 rd idle", 64'(mem_rd_req), 0);

    // R6/R7 FIFO in set 0 (block offset 2 bits, set bit is address bit 2)
    access(0, 'h000, 4'hF, '0, h);
    access(0, 'h008, 4'h3, '0, h);
    access(0, 'h010, 4'hC, '0, h);
    access(0, 'h018, 4'h1, '0, h);
    check("R7 no evict on invalid fill", 64'(evict_cnt), 0);
    access(0, 'h004, 4'hF, '0, h);           // R1 set 1
    access(0, 'h000, 4'h2, '0, h);
    check("R6 hit before eviction", 64'(h), 1);
    access(0, 'h020, 4'hF, '0, h);
    check("R7 eviction counted", 64'(evict_cnt), 1);
    access(0, 'h000, 4'hF, '0, h);
    check("R6 earliest fill evicted despite hit", 64'(h), 0);
    access(0, 'h010, 4'hF, '0, h);
    check("R6 later fill kept", 64'(h), 1);
    access(3, 'h004, 4'h8, '0, h);
    check("R1 other set undisturbed, R10 op3 as load", 64'(h), 1);
    // R5 store miss, no allocate
    access(1, 'h034, 4'h5, 32'hA1B2C3D4, h);
    access(0, 'h034, 4'hF, '0, h);
    check("R5 no allocate on store miss", 64'(h), 0);
    // R4 store hit then load sees new bytes
    access(1, 'h034, 4'h6, 32'h11223344, h);
    access(0, 'h034, 4'hF, '0, h);
    // R8 modify hit and miss
    access(2, 'h034, 4'h9, 32'h55667788, h);
    access(0, 'h034, 4'hF, '0, h);
    access(2, 'h07C, 4'hF, 32'hDEADBEEF, h);
    check("R8 modify miss", 64'(h), 0);
    access(0, 'h07C, 4'hF, '0, h);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int op = $urandom_range(0, 3);
      access(op, $urandom_range(0, 127), 4'($urandom_range(1, 15)), 32'($urandom), h);
    end

    // R9 reset clears valid state and counters
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    ref_reset();
    @(negedge clk);
    check("R9 hit_cnt cleared", 64'(hit_cnt), 0);
    check("R9 miss_cnt cleared", 64'(miss_cnt), 0);
    check("R9 evict_cnt cleared", 64'(evict_cnt), 0);
    access(0, 'h034, 4'hF, '0, h);
    check("R9 lines invalid after reset", 64'(h), 0);
    finish_run();
  end
endmodule